// File: doc/BRIEF.md
# LED Driver Chain Refresh Sequencer

This block feeds a serial chain of constant-current LED driver chips over a transmit-only SPI link. The drivers come in groups of three. Each group lights ten RGB pixels, and each driver has ten PWM channels. The first start pulse after reset configures every chip before any pixel data goes out. The block sends three setup words: the current for the low eight channels, the current for the top two channels, and a final word that turns on PWM staggering and takes the chip out of shutdown. Each setup word is sent in its own chip-select window and is repeated once for every chip in the chain.

Each start pulse then sends one full-frame refresh. The refresh has ten chip-select windows, one for each channel number. In every window, each driver in the chain receives one address/data word for that channel. Pixel bytes come from an external frame memory that stores red, green and blue bytes for each LED. They are fetched through a fixed per-driver permutation that reflects how the board routes LEDs to pins. Each byte is then recoded into the drivers' duty-cycle code before it is shifted out.

Top module: `led_chain_refresh`

## Requirements
- R1: The first start after reset is preceded by three setup windows carrying 0x13FF, 0x1403 and 0x1021, in that order. Each window holds 3*N_TRIADS copies of its word, and no frame memory read is made during these windows.
- R2: A refresh consists of exactly 10 chip-select windows, each holding 3*N_TRIADS 16-bit words. The upper byte of each word in window c is the channel number c, for c = 0 to 9 in ascending order.
- R3: Word k of a window (k = 0 first) targets triad N_TRIADS-1-k/3 and driver 2-k%3. Its pixel byte comes from address 30*triad + offset(driver, channel), and that address is always below 30*N_TRIADS.
- R4: The offsets for channels 0..9 are as follows. Driver 0: 10,8,6,7,5,3,4,2,0,1. Driver 1: 18,19,17,15,16,14,12,13,11,9. Driver 2: 29,27,28,26,24,25,23,21,22,20.
- R5: The low byte of a word is the recoded pixel byte d. If d = 0 it is 0xFF (dark). If d is 0xFD or higher it is 0x02 (full on). Otherwise it is d+2.
- R6: The serial link uses SPI mode 0, MSB first. SCLK is low whenever chip select changes and whenever the block is idle. MOSI is stable while SCLK is high. Every window carries a whole number of 16-bit words.
- R7: Each SCLK high phase lasts exactly div_i+1 system clocks.
- R8: Between two consecutive windows, chip select stays high for at least 2*(div_i+1) system clocks.
- R9: busy_o rises on the clock edge after an accepted start and falls on the same edge as the last chip-select rise of the refresh. A start while busy is ignored, and chip select is low only while busy is high.
- R10: During reset, cs_no is 1, and sclk_o, busy_o and mem_rd_o are 0.
- R11: Frame memory has one-cycle read latency. A refresh issues exactly 30*N_TRIADS read strobes, one before each data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request for a refresh |
| div_i | input | DIV_W | SCLK half period minus one, in system clocks |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_addr_o | output | ADDR_W | Frame memory byte address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the strobe |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI serial data out |
| cs_no | output | 1 | Active-low chip select for the whole chain |
| busy_o | output | 1 | Setup or refresh in progress |

## Verification
The bench builds the block with N_TRIADS=2 and DIV_W=8. Two triads are the smallest chain in which the triad countdown and the 30-byte triad offset both show up in the word order. Five refreshes load the frame memory with consecutive byte values, which together cover all 256 intensities and so every branch of the recoding. The refreshes run with divider values 0 to 3, so the SCLK phase lengths and chip-select gaps are checked at several speeds. One run pulses start in the middle of a refresh.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
  localparam int unsigned DRV_PER_TRIAD = 3;
  localparam int unsigned CH_PER_DRV    = 10;
  localparam int unsigned BYTES_PER_TRI = 30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_FETCH, ST_LOAD, ST_SHIFT, ST_END
  } seq_st_e;

  function automatic logic [7:0] duty_code(input logic [7:0] level);
    logic [7:0] v;
    v = (level >= 8'hFD) ? 8'hFF : level + 8'd2;
    if (v == 8'hFF)      return 8'h02;
    else if (v == 8'h02) return 8'hFF;
    else                 return v;
  endfunction

  function automatic logic [15:0] setup_word(input logic [1:0] ph);
    case (ph)
      2'd0:    return 16'h13FF;
      2'd1:    return 16'h1403;
      default: return 16'h1021;
    endcase
  endfunction

  // board routing: byte offset inside a triad for (driver, channel)
  function automatic logic [4:0] chan_offset(input logic [1:0] drv, input logic [3:0] ch);
    int idx;
    idx = int'(drv) * 10 + int'(ch);
    case (idx)
      0: return 5'd10;  1: return 5'd8;   2: return 5'd6;   3: return 5'd7;
      4: return 5'd5;   5: return 5'd3;   6: return 5'd4;   7: return 5'd2;
      8: return 5'd0;   9: return 5'd1;
      10: return 5'd18; 11: return 5'd19; 12: return 5'd17; 13: return 5'd15;
      14: return 5'd16; 15: return 5'd14; 16: return 5'd12; 17: return 5'd13;
      18: return 5'd11; 19: return 5'd9;
      20: return 5'd29; 21: return 5'd27; 22: return 5'd28; 23: return 5'd26;
      24: return 5'd24; 25: return 5'd25; 26: return 5'd23; 27: return 5'd21;
      28: return 5'd22; 29: return 5'd20;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/led_chain_tick.sv
module led_chain_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_chain_shift.sv
module led_chain_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  bit_q;
  logic              act_q, sclk_q, done_q;

  assign sclk_o = sclk_q;
  assign mosi_o = sr_q[WORD_W-1];
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; bit_q <= '0; act_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !act_q) begin
        sr_q <= word_i; bit_q <= '0; act_q <= 1'b1; sclk_q <= 1'b0;
      end else if (act_q && tick_i) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;                 // receiver samples here
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == CNT_W'(WORD_W - 1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/led_chain_refresh.sv
module led_chain_refresh
  import led_chain_pkg::*;
#(
  parameter int unsigned N_TRIADS = 2,
  parameter int unsigned DIV_W    = 8,
  localparam int unsigned ADDR_W  = $clog2(BYTES_PER_TRI * N_TRIADS),
  localparam int unsigned TRI_W   = (N_TRIADS > 1) ? $clog2(N_TRIADS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              busy_o
);
  seq_st_e          st_q;
  logic             busy_q, cs_nq, setup_done_q, in_setup_q, gap_q;
  logic [1:0]       ph_q, drv_q;
  logic [3:0]       chan_q;
  logic [TRI_W-1:0] tri_q;
  logic             tick, sh_done;
  logic [15:0]      sh_word;

  led_chain_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  led_chain_shift #(.WORD_W(16)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .load_i(st_q == ST_LOAD), .word_i(sh_word),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(sh_done)
  );

  always_comb begin
    mem_addr_o = ADDR_W'(tri_q) * ADDR_W'(BYTES_PER_TRI) + ADDR_W'(chan_offset(drv_q, chan_q));
    mem_rd_o   = (st_q == ST_FETCH) && !in_setup_q;
    sh_word    = in_setup_q ? setup_word(ph_q) : {4'b0, chan_q, duty_code(mem_rdata_i)};
  end

  assign cs_no  = cs_nq;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; busy_q <= 1'b0; cs_nq <= 1'b1; setup_done_q <= 1'b0;
      in_setup_q <= 1'b0; gap_q <= 1'b0; ph_q <= '0; drv_q <= '0;
      chan_q <= '0; tri_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          busy_q     <= 1'b1;
          in_setup_q <= !setup_done_q;
          ph_q       <= '0;
          chan_q     <= '0;
          gap_q      <= 1'b0;
          st_q       <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_q) begin
            cs_nq <= 1'b0;
            tri_q <= TRI_W'(N_TRIADS - 1);   // farthest word first
            drv_q <= 2'd2;
            st_q  <= ST_FETCH;
          end else begin
            gap_q <= 1'b1;
          end
        end
        ST_FETCH: st_q <= ST_LOAD;
        ST_LOAD:  st_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          if (tri_q == '0 && drv_q == 2'd0) begin
            st_q <= ST_END;
          end else begin
            if (drv_q == 2'd0) begin
              drv_q <= 2'd2;
              tri_q <= tri_q - 1'b1;
            end else begin
              drv_q <= drv_q - 1'b1;
            end
            st_q <= ST_FETCH;
          end
        end
        ST_END: if (tick) begin
          cs_nq <= 1'b1;
          gap_q <= 1'b0;
          if (in_setup_q) begin
            if (ph_q == 2'd2) begin
              in_setup_q   <= 1'b0;
              setup_done_q <= 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
            st_q <= ST_GAP;
          end else if (chan_q == 4'(CH_PER_DRV - 1)) begin
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            chan_q <= chan_q + 1'b1;
            st_q   <= ST_GAP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_chain_refresh_chk.sv
module led_chain_refresh_chk #(
  parameter int unsigned N_TRIADS = 2,
  parameter int unsigned AW       = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          sclk_o,
  input logic          mosi_o,
  input logic          cs_no,
  input logic          busy_o
);
  assert_sclk_quiet_cs_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no != $past(cs_no)) |-> (!sclk_o && !$past(sclk_o)));

  assert_sclk_inside_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  assert_mosi_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (int'(mem_addr_o) < 30 * int'(N_TRIADS)));

  assert_read_in_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !cs_no);

  assert_idle_cs_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  assert_start_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind led_chain_refresh led_chain_refresh_chk #(.N_TRIADS(N_TRIADS), .AW(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mem_rd_o(mem_rd_o),
  .mem_addr_o(mem_addr_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no),
  .busy_o(busy_o)
);

// File: tb/led_chain_refresh_bench.sv
module led_chain_refresh_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT  = 2;
  localparam int NW  = 3 * NT;
  localparam int MB  = 30 * NT;
  localparam int AW  = $clog2(MB);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] div = 8'd0;
  logic rd, sclk, mosi, cs_n, busy;
  logic [AW-1:0] addr;
  logic [7:0] rdata = 8'd0;
  logic [7:0] mem [MB];

  int checks = 0, errors = 0;

  led_chain_refresh #(.N_TRIADS(NT), .DIV_W(8)) u_led_chain_refresh (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
    .mem_rd_o(rd), .mem_addr_o(addr), .mem_rdata_i(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rd) rdata <= mem[addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int off_ref(input int drv, input int ch);
    int t0[10] = '{10, 8, 6, 7, 5, 3, 4, 2, 0, 1};
    int t1[10] = '{18, 19, 17, 15, 16, 14, 12, 13, 11, 9};
    int t2[10] = '{29, 27, 28, 26, 24, 25, 23, 21, 22, 20};
    if (drv == 0) return t0[ch];
    if (drv == 1) return t1[ch];
    return t2[ch];
  endfunction

  function automatic int code_ref(input int d);
    if (d == 0) return 'hFF;
    if (d >= 'hFD) return 'h02;
    return d + 2;
  endfunction

  // capture of SPI traffic
  bit cap_en = 1'b0;
  int nbits, nwords, nwin, prev_w, frag, rd_cnt, rd_setup;
  logic [15:0] shreg;
  logic [15:0] cap_w [128];
  int win_cnt [16];

  always @(posedge sclk) if (cap_en && !cs_n) begin
    shreg = {shreg[14:0], mosi};
    nbits++;
    if (nbits % 16 == 0 && nwords < 128) begin
      cap_w[nwords] = shreg;
      nwords++;
    end
  end

  always @(posedge cs_n) if (cap_en) begin
    if (nwin < 16) win_cnt[nwin] = nwords - prev_w;
    prev_w = nwords;
    if (nbits % 16 != 0) frag++;
    nwin++;
  end

  // timing monitor, sampled mid-cycle
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  int hi_len = 0, cs_hi = 1000;
  bit exp_setup = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (sclk) hi_len++;
    if (prev_sclk && !sclk) begin
      chk(hi_len == int'(div) + 1, "R7 sclk high length", hi_len, int'(div) + 1);
      hi_len = 0;
    end
    if (cs_n != prev_cs) chk(!sclk, "R6 sclk low at cs edge", sclk, 0);
    if (cs_n) begin
      if (!prev_cs) cs_hi = 0;
      cs_hi++;
    end else if (prev_cs) begin
      chk(cs_hi >= 2 * (int'(div) + 1), "R8 cs high gap", cs_hi, 2 * (int'(div) + 1));
    end
    if (!cs_n && !busy) chk(1'b0, "R9 cs low while idle", busy, 1);
    if (cap_en && rd) begin
      rd_cnt++;
      if (exp_setup && nwin < 3) rd_setup++;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic run_op(input bit with_setup, input int dv, input int pat, input bit extra_start);
    int cyc, nexp, t, dr, c, d, w, expw;
    int sw[3] = '{'h13FF, 'h1403, 'h1021};
    div = 8'(dv);
    for (int a = 0; a < MB; a++) mem[a] = 8'(pat * 60 + a);
    nbits = 0; nwords = 0; nwin = 0; prev_w = 0; frag = 0; rd_cnt = 0; rd_setup = 0;
    exp_setup = with_setup;
    @(negedge clk);
    cap_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    cyc = 0;
    while (busy && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      start = (extra_start && (cyc == 500 || cyc == 501));
    end
    start = 1'b0;
    chk(!busy, "R9 busy falls (watchdog)", busy, 0);
    chk(cs_n == 1'b1, "R9 cs high at busy fall", cs_n, 1);
    repeat (4 * (dv + 1) + 30) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R9 no restart from ignored start", {busy, cs_n}, 1);
    cap_en = 1'b0;
    nexp = with_setup ? 13 : 10;
    chk(nwin == nexp, "R2 window count", nwin, nexp);
    chk(frag == 0, "R6 whole words per window", frag, 0);
    chk(nwords == nexp * NW, "R2 word count", nwords, nexp * NW);
    chk(rd_cnt == 10 * NW, "R11 read strobes per refresh", rd_cnt, 10 * NW);
    if (with_setup) chk(rd_setup == 0, "R1 no reads during setup", rd_setup, 0);
    if (nwin == nexp && nwords == nexp * NW) begin
      for (int win = 0; win < nexp; win++) begin
        chk(win_cnt[win] == NW, "R2 words per window", win_cnt[win], NW);
        for (int k = 0; k < NW; k++) begin
          w = win * NW + k;
          if (with_setup && win < 3) begin
            chk(int'(cap_w[w]) == sw[win], "R1 setup word", cap_w[w], sw[win]);
          end else begin
            c  = with_setup ? win - 3 : win;
            t  = NT - 1 - k / 3;
            dr = 2 - k % 3;
            d  = int'(mem[30 * t + off_ref(dr, c)]);
            expw = (c << 8) | code_ref(d);
            chk(int'(cap_w[w]) == expw, "R2 R3 R4 R5 refresh word", cap_w[w], expw);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && rd == 1'b0,
        "R10 reset state", {cs_n, sclk, busy, rd}, 'b1000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R10 idle after reset",
        {cs_n, sclk, busy}, 'b100);
    run_op(1'b1, 0, 0, 1'b0);
    run_op(1'b0, 1, 1, 1'b1);
    run_op(1'b0, 3, 2, 1'b0);
    run_op(1'b0, 0, 3, 1'b1);
    run_op(1'b0, 2, 4, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule